// File: doc/BRIEF.md
# Serial memory status and write-protection controller

This block sits behind the serial command decoder of a small byte-wide nonvolatile memory. It keeps the write-enable latch, the three nonvolatile protection bits (pin-lock enable and a two-bit block-protect code) and the ready/busy flag, and it assembles the status byte that the decoder shifts out. The decoder reports decoded events to it as single-cycle pulses in the system clock domain: enable and disable commands, the completion of each full data byte of an array or status write, each rising serial clock edge, and the rising edge of chip select. The block samples the active-low protect pin directly.

A write is armed when a full data byte has arrived while writes are enabled. It starts only if chip select rises before the next serial clock edge. The block then checks the request against the protection state. An array write is refused if its address falls in the protected range. A status write is refused if the pin lock is active. A write that passes runs a self-timed cycle whose length is a clock-cycle parameter. During that cycle the block reports busy and refuses every other request. The protection bits are plain flops cleared only by the power-up reset.

Top module: `eeprom_status_ctl`

## Requirements
- R1: After reset the status byte is 0x00, busy is 0 and array_commit is 0.
- R2: Status byte layout: bit 7 is the pin-lock enable, bits 6..4 are 0, bit 3 is block-protect high, bit 2 is block-protect low, bit 1 is the write-enable latch and bit 0 is busy (1 = write cycle running).
- R3: A req_wren pulse sets the write-enable latch and a req_wrdi pulse clears it. The new value is visible on the cycle after the pulse.
- R4: A write request that arrives while the latch is 0 is ignored: a following cs_rise gives no commit and no busy.
- R5: A write starts only if cs_rise comes after an arm pulse and before any sck_rise. A cs_rise that comes after an sck_rise, or with nothing armed, cancels the write: no commit, no busy, and the latch is left unchanged.
- R6: A started write drives busy (and status bit 0) high from the cycle after cs_rise for exactly WCYC cycles. A started array write also pulses array_commit for one cycle, on the cycle after cs_rise. A page write (several arm pulses, each followed by sck_rise, ending with cs_rise) commits once.
- R7: The write-enable latch clears on the cs_rise that ends an armed write, whether the write is accepted or refused.
- R8: The block-protect code refuses array writes as follows (10-bit address): 00 refuses none, 01 refuses 0x300..0x3FF, 10 refuses 0x200..0x3FF, 11 refuses all addresses. A refused write gives no commit and no busy.
- R9: An accepted status write loads req_nv_bits[2], [1] and [0] into the pin-lock enable, block-protect high and block-protect low bits, at the start of the cycle.
- R10: When the pin-lock enable is 1 and wp_n is 0, status writes are refused. When the pin-lock enable is 0, wp_n has no effect. wp_n never affects array writes.
- R11: While busy, req_wren, req_wrdi, arm pulses and cs_rise are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| req_wren | input | 1 | Enable-writes command pulse |
| req_wrdi | input | 1 | Disable-writes command pulse |
| req_arm_array | input | 1 | Full data byte of an array write received |
| req_arm_status | input | 1 | Full data byte of a status write received |
| req_addr | input | ADDR_W | Array write address, valid with req_arm_array |
| req_nv_bits | input | 3 | {pin-lock enable, protect high, protect low} taken from status data bits 7, 3, 2 |
| sck_rise | input | 1 | Pulse on each rising serial clock edge |
| cs_rise | input | 1 | Pulse on the rising edge of chip select |
| wp_n | input | 1 | Protect pin, active low |
| status_byte | output | 8 | Readable status byte |
| busy | output | 1 | Write cycle running |
| array_commit | output | 1 | One-cycle pulse: program the array now |

## Verification
The assertions assume that the decoder raises at most one of req_wren, req_wrdi, req_arm_array and req_arm_status in any cycle. They also assume that wp_n is already synchronous to clk. The bench drives every request as a one-cycle pulse set up away from the active edge, and it never overlaps two command pulses. The busy-length and freeze checks rely on cs_rise being the only trigger of a cycle. So the stimulus also sends cs_rise pulses while busy, to show that they have no effect.

// File: rtl/eep_stat_pkg.sv
package eep_stat_pkg;

   typedef enum logic [1:0] {
      WK_NONE   = 2'd0,
      WK_ARRAY  = 2'd1,
      WK_STATUS = 2'd2
   } wkind_e;

   typedef struct packed {
      logic       lock_en;
      logic [1:0] bp;
   } nvbits_t;

   localparam logic [1:0] BP_OFF  = 2'b00;
   localparam logic [1:0] BP_QTR  = 2'b01;
   localparam logic [1:0] BP_HALF = 2'b10;
   localparam logic [1:0] BP_ALL  = 2'b11;

   function automatic logic [7:0] pack_status(input nvbits_t nv, input logic wen,
                                              input logic bsy);
      pack_status = {nv.lock_en, 3'b000, nv.bp, wen, bsy};
   endfunction

endpackage

// File: rtl/esc_block_guard.sv
module esc_block_guard
   import eep_stat_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic [1:0]        bp,
   input  logic [ADDR_W-1:0] addr,
   output logic              locked
);
   localparam logic [ADDR_W-1:0] QTR_BASE  = {2'b11, {(ADDR_W-2){1'b0}}};
   localparam logic [ADDR_W-1:0] HALF_BASE = {1'b1, {(ADDR_W-1){1'b0}}};

   generate
      if (ADDR_W < 3) begin : g_bad_width
         $error("esc_block_guard: ADDR_W must be at least 3");
      end
   endgenerate

   always_comb begin
      unique case (bp)
         BP_OFF:  locked = 1'b0;
         BP_QTR:  locked = (addr >= QTR_BASE);
         BP_HALF: locked = (addr >= HALF_BASE);
         default: locked = 1'b1;
      endcase
   end

   always_comb begin
      if (bp == BP_ALL) assert_full_lock_R8: assert (locked);
      if (bp == BP_OFF) assert_no_lock_R8: assert (!locked);
   end

endmodule

// File: rtl/esc_arm_window.sv
module esc_arm_window
   import eep_stat_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              arm_array,
   input  logic              arm_status,
   input  logic [ADDR_W-1:0] addr,
   input  logic [2:0]        nv_bits,
   input  logic              sck_rise,
   input  logic              cs_rise,
   output logic              armed,
   output wkind_e            kind,
   output logic [ADDR_W-1:0] held_addr,
   output nvbits_t           held_nv
);
   logic armed_q;
   wkind_e kind_q;
   logic [ADDR_W-1:0] addr_q;
   nvbits_t nv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         kind_q  <= WK_NONE;
         addr_q  <= '0;
         nv_q    <= '0;
      end else if (en && arm_array) begin
         armed_q <= 1'b1;
         kind_q  <= WK_ARRAY;
         addr_q  <= addr;
      end else if (en && arm_status) begin
         armed_q <= 1'b1;
         kind_q  <= WK_STATUS;
         nv_q    <= nv_bits;
      end else if (sck_rise || cs_rise || !en) begin
         armed_q <= 1'b0;
      end
   end

   assign armed     = armed_q;
   assign kind      = kind_q;
   assign held_addr = addr_q;
   assign held_nv   = nv_q;

   assert_arm_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !armed_q) |=> !armed_q);
   assert_sck_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_rise && !arm_array && !arm_status) |=> !armed_q);

endmodule

// File: rtl/esc_busy_timer.sv
module esc_busy_timer #(
   parameter int WCYC = 500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CW = $clog2(WCYC + 1);

   generate
      if (WCYC < 1) begin : g_bad_len
         $error("esc_busy_timer: WCYC must be at least 1");
      end else if (WCYC == 1) begin : g_single
         logic b_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) b_q <= 1'b0;
            else        b_q <= start;
         end
         assign busy = b_q;
      end else begin : g_count
         localparam logic [CW-1:0] LOAD = CW'(WCYC - 1);
         logic b_q;
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               b_q   <= 1'b0;
               cnt_q <= '0;
            end else if (!b_q) begin
               if (start) begin
                  b_q   <= 1'b1;
                  cnt_q <= LOAD;
               end
            end else if (cnt_q == '0) begin
               b_q <= 1'b0;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
         assign busy = b_q;
      end
   endgenerate

   assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

endmodule

// File: rtl/eeprom_status_ctl.sv
module eeprom_status_ctl
   import eep_stat_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int WCYC   = 500000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_wren,
   input  logic              req_wrdi,
   input  logic              req_arm_array,
   input  logic              req_arm_status,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [2:0]        req_nv_bits,
   input  logic              sck_rise,
   input  logic              cs_rise,
   input  logic              wp_n,
   output logic [7:0]        status_byte,
   output logic              busy,
   output logic              array_commit
);
   localparam int LW = $clog2(WCYC + 2);
   localparam logic [LW-1:0] LEN_EXP = LW'(WCYC);

   logic wen_q, commit_q;
   nvbits_t nv_q;
   logic armed, locked_arr, st_lock, cs_take, permit, start;
   wkind_e kind;
   logic [ADDR_W-1:0] held_addr;
   nvbits_t held_nv;

   esc_arm_window #(.ADDR_W(ADDR_W)) u_win (
      .clk(clk), .rst_n(rst_n), .en(wen_q && !busy),
      .arm_array(req_arm_array), .arm_status(req_arm_status),
      .addr(req_addr), .nv_bits(req_nv_bits),
      .sck_rise(sck_rise), .cs_rise(cs_rise),
      .armed(armed), .kind(kind), .held_addr(held_addr), .held_nv(held_nv)
   );

   esc_block_guard #(.ADDR_W(ADDR_W)) u_guard (
      .bp(nv_q.bp), .addr(held_addr), .locked(locked_arr)
   );

   esc_busy_timer #(.WCYC(WCYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy)
   );

   assign st_lock = nv_q.lock_en && !wp_n;
   assign cs_take = cs_rise && armed && wen_q && !busy;
   assign permit  = (kind == WK_ARRAY)  ? !locked_arr :
                    (kind == WK_STATUS) ? !st_lock : 1'b0;
   assign start   = cs_take && permit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wen_q    <= 1'b0;
         nv_q     <= '0;
         commit_q <= 1'b0;
      end else begin
         commit_q <= start && (kind == WK_ARRAY);
         if (!busy) begin
            if (cs_take)       wen_q <= 1'b0;
            else if (req_wren) wen_q <= 1'b1;
            else if (req_wrdi) wen_q <= 1'b0;
            if (start && kind == WK_STATUS) nv_q <= held_nv;
         end
      end
   end

   assign status_byte  = pack_status(nv_q, wen_q, busy);
   assign array_commit = commit_q;

   // checker state: length of the current busy run
   logic [LW-1:0] run_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_len <= '0;
      else if (busy) run_len <= run_len + 1'b1;
      else           run_len <= '0;
   end

   assert_req_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_wren, req_wrdi, req_arm_array, req_arm_status}));
   assert_wen_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cs_take |=> !wen_q);
   assert_commit_wen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      array_commit |-> $past(wen_q));
   assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_len == LEN_EXP));
   assert_pin_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (nv_q.lock_en && !wp_n) |=> $stable(nv_q));
   assert_busy_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(wen_q) && $stable(nv_q)));

endmodule

// File: tb/eeprom_status_ctl_tb.sv
module eeprom_status_ctl_tb;
   localparam int AW = 10;
   localparam int WC = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_wren = 0, req_wrdi = 0, req_arm_array = 0, req_arm_status = 0;
   logic [AW-1:0] req_addr = '0;
   logic [2:0] req_nv_bits = '0;
   logic sck_rise = 0, cs_rise = 0, wp_n = 1;
   logic [7:0] status_byte;
   logic busy, array_commit;

   integer n_chk = 0, n_bad = 0;

   always #5 clk = ~clk;

   eeprom_status_ctl #(.ADDR_W(AW), .WCYC(WC)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_wren(req_wren), .req_wrdi(req_wrdi),
      .req_arm_array(req_arm_array), .req_arm_status(req_arm_status),
      .req_addr(req_addr), .req_nv_bits(req_nv_bits), .sck_rise(sck_rise),
      .cs_rise(cs_rise), .wp_n(wp_n), .status_byte(status_byte), .busy(busy),
      .array_commit(array_commit)
   );

   function automatic logic [7:0] es(input logic [2:0] nv, input logic w, input logic b);
      es = {nv[2], 3'b000, nv[1:0], w, b};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                      input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step; @(negedge clk); endtask
   task automatic p_wren; req_wren = 1; step; req_wren = 0; endtask
   task automatic p_wrdi; req_wrdi = 1; step; req_wrdi = 0; endtask
   task automatic p_sck;  sck_rise = 1; step; sck_rise = 0; endtask
   task automatic p_cs;   cs_rise  = 1; step; cs_rise  = 0; endtask
   task automatic p_arm_a(input logic [AW-1:0] a);
      req_addr = a; req_arm_array = 1; step; req_arm_array = 0;
   endtask
   task automatic p_arm_s(input logic [2:0] v);
      req_nv_bits = v; req_arm_status = 1; step; req_arm_status = 0;
   endtask
   task automatic wait_idle;
      for (int i = 0; i < WC + 4 && busy; i++) step;
   endtask
   task automatic set_nv(input logic [2:0] v);
      wp_n = 1; p_wren; p_arm_s(v); p_cs; wait_idle;
   endtask

   task automatic t_reset;
      chk(status_byte == 8'h00, "R1 status after reset", status_byte, 8'h00);
      chk(!busy && !array_commit, "R1 busy/commit after reset", {busy, array_commit}, 0);
   endtask

   task automatic t_wen;
      p_wren;
      chk(status_byte == es(3'b000, 1, 0), "R3 R2 wren sets bit1", status_byte, es(3'b000, 1, 0));
      p_wrdi;
      chk(status_byte == 8'h00, "R3 wrdi clears bit1", status_byte, 8'h00);
   endtask

   task automatic t_no_wen;
      p_arm_a(10'h010); p_cs;
      chk(!array_commit && !busy, "R4 write with latch clear", {array_commit, busy}, 0);
   endtask

   task automatic t_cancel;
      p_wren; p_arm_a(10'h020); p_sck; p_cs;
      chk(!array_commit && !busy, "R5 cs after sck cancels", {array_commit, busy}, 0);
      chk(status_byte == es(3'b000, 1, 0), "R5 latch kept on cancel", status_byte, es(3'b000, 1, 0));
      p_cs;
      chk(!array_commit && !busy, "R5 cs with nothing armed", {array_commit, busy}, 0);
      p_wrdi;
   endtask

   task automatic t_array_write;
      int n;
      p_wren; p_arm_a(10'h010); p_cs;
      chk(array_commit == 1, "R6 commit pulse", array_commit, 1);
      chk(status_byte == es(3'b000, 0, 1), "R7 R2 latch cleared busy set", status_byte, es(3'b000, 0, 1));
      n = busy ? 1 : 0;
      step;
      chk(array_commit == 0, "R6 commit is one cycle", array_commit, 0);
      if (busy) n++;
      for (int i = 0; i < WC + 4; i++) begin
         step;
         if (busy) n++;
      end
      chk(n == WC, "R6 busy length", 16'(n), 16'(WC));
   endtask

   task automatic t_page;
      int c;
      p_wren;
      p_arm_a(10'h040); p_sck; p_arm_a(10'h041); p_sck; p_arm_a(10'h042);
      c = 0;
      p_cs; if (array_commit) c++;
      for (int i = 0; i < WC + 4; i++) begin step; if (array_commit) c++; end
      chk(c == 1, "R6 page write commits once", 16'(c), 1);
   endtask

   task automatic t_status_write;
      p_wren; p_arm_s(3'b111); p_cs;
      chk(status_byte == es(3'b111, 0, 1), "R9 status write during busy", status_byte, es(3'b111, 0, 1));
      chk(array_commit == 0, "R9 status write no array commit", array_commit, 0);
      wait_idle;
      chk(status_byte == 8'h8C, "R9 R2 status byte after write", status_byte, 8'h8C);
      set_nv(3'b000);
      chk(status_byte == 8'h00, "R9 status cleared", status_byte, 8'h00);
   endtask

   task automatic t_protect;
      logic [AW-1:0] al [5];
      al[0] = 10'h000; al[1] = 10'h1FF; al[2] = 10'h200; al[3] = 10'h2FF; al[4] = 10'h3FF;
      for (int b = 0; b < 4; b++) begin
         set_nv({1'b0, 2'(b)});
         for (int k = 0; k < 5; k++) begin
            bit ok;
            ok = !((b == 3) || (b == 2 && al[k] >= 10'h200) || (b == 1 && al[k] >= 10'h300));
            p_wren; p_arm_a(al[k]); p_cs;
            chk(array_commit == ok, "R8 block protect commit", {6'(b), al[k]}, 16'(ok));
            chk(status_byte == es({1'b0, 2'(b)}, 0, ok), "R7 latch cleared after attempt",
                status_byte, es({1'b0, 2'(b)}, 0, ok));
            wait_idle;
         end
      end
      set_nv(3'b000);
   endtask

   task automatic t_wp;
      set_nv(3'b100);
      wp_n = 0;
      p_wren; p_arm_s(3'b011); p_cs;
      chk(!busy, "R10 status write pin locked", busy, 0);
      chk(status_byte == 8'h80, "R10 bits kept, latch cleared", status_byte, 8'h80);
      p_wren; p_arm_a(10'h000); p_cs;
      chk(array_commit == 1, "R10 array write ignores pin", array_commit, 1);
      wait_idle;
      wp_n = 1;
      p_wren; p_arm_s(3'b000); p_cs; wait_idle;
      chk(status_byte == 8'h00, "R10 pin high allows status write", status_byte, 8'h00);
      wp_n = 0;
      p_wren; p_arm_s(3'b001); p_cs; wait_idle;
      chk(status_byte == 8'h04, "R10 pin ignored with lock off", status_byte, 8'h04);
      set_nv(3'b000);
   endtask

   task automatic t_busy_ignore;
      p_wren; p_arm_a(10'h005); p_cs;
      p_wren;
      chk(status_byte == es(3'b000, 0, 1), "R11 wren ignored while busy", status_byte, es(3'b000, 0, 1));
      p_arm_a(10'h006); p_cs;
      chk(array_commit == 0, "R11 cs ignored while busy", array_commit, 0);
      wait_idle;
      p_cs;
      chk(!array_commit && !busy, "R11 arm during busy dropped", {array_commit, busy}, 0);
      chk(status_byte == 8'h00, "R11 status after busy", status_byte, 8'h00);
   endtask

   initial begin
      repeat (3) step;
      rst_n = 1;
      step;
      t_reset;
      t_wen;
      t_no_wen;
      t_cancel;
      t_array_write;
      t_page;
      t_status_write;
      t_protect;
      t_wp;
      t_busy_ignore;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule